// File: doc/BRIEF.md
# Programmable Two-Plane Sum-of-Products Array

The block evaluates a set of Boolean functions in sum-of-products form from a personality held in registers. A first plane stores one row per product term; each row gives every input a two-bit literal code that puts the input in the term as is, puts it in inverted, leaves it out, or forces the whole term to zero. A second plane stores one mask per output. The mask picks the product terms that the output ORs together, so a single term can drive any number of outputs.

Software or a loader writes the personality one word at a time through a synchronous port. A plane-select bit picks the term plane or the output plane, and an index picks the row or mask. Evaluation from `in_vec` to `out_vec` is purely combinational. A build-time switch selects a restricted variant in which each output reaches only its own fixed group of terms. All other mask bits are then ignored.

Top module: `pla_array`

## Requirements
- R1: After reset every term row holds code 2'b00 on every input and every output mask is zero, so `out_vec` is 0 for every input value.
- R2: The literal code for input j sits at bits [2j+1:2j] of a term-plane write word: 2'b01 requires the input to be 1, 2'b10 requires it to be 0, 2'b11 leaves it out, and 2'b00 makes the term 0 whatever the inputs are.
- R3: A term whose codes are all 2'b11 evaluates to 1 for every input value.
- R4: Output k is the OR of all terms t whose bit t is set in output k's mask; a term with its mask bit clear has no effect on that output.
- R5: One term may feed several outputs at once: the five terms AB, B'C, AC', B'C' and A together give F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A.
- R6: A write with `cfg_plane` = 0 loads term row `cfg_index`, and a write with `cfg_plane` = 1 loads the mask of output `cfg_index`. The new content takes effect at the clock edge that samples `cfg_we` high, and no content changes while `cfg_we` is low.
- R7: An output-plane write whose index is not below the output count changes nothing.
- R8: In the restricted variant, output k uses only terms G*k to G*k+G-1 (G = 4 by default), and its mask bits outside that group are ignored.
- R9: The array realises a BCD-to-Gray converter with W = A + BD + BC, X = BC', Y = B + C and Z = A'B'C'D + BCD + AD' + B'CD' for all sixteen input values, in both variants.
- R10: `out_vec` follows a change of `in_vec` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst | input | 1 | Synchronous active-high reset of both planes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_plane | input | 1 | 0 = term plane, 1 = output plane |
| cfg_index | input | IDX_W (4) | Term row or output mask to write |
| cfg_data | input | DATA_W (16) | Row codes or mask bits |
| in_vec | input | N_IN (4) | Function inputs |
| out_vec | output | N_OUT (4) | Function outputs |

## Verification
Every personality is checked against all sixteen input values. Single-literal terms show that each of the four codes and the bit order of inputs decode correctly. The shared-term personality shows that one term row can feed several masks without disturbing them. The BCD-to-Gray personality is loaded into both variants at once, so the two must agree where the groups allow it. A mask with bits set only outside an output's group then tells the variants apart: the full array lights the output and the restricted one keeps it at 0. A write held against the clock edge fixes the cycle in which new content appears. A stray output-plane index and an idle strobe with changing data must both leave the outputs as they were.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

    typedef enum logic [1:0] {
        LIT_KILL = 2'b00,
        LIT_POS  = 2'b01,
        LIT_NEG  = 2'b10,
        LIT_SKIP = 2'b11
    } lit_code_e;

    typedef enum logic {
        PLANE_TERM = 1'b0,
        PLANE_SUM  = 1'b1
    } plane_sel_e;

    typedef struct packed {
        logic       we;
        plane_sel_e plane;
    } cfg_ctl_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // One literal of one term: does this input let the term stay true?
    function automatic logic literal_ok(input lit_code_e code, input logic x);
        case (code)
            LIT_POS:  return x;
            LIT_NEG:  return ~x;
            LIT_SKIP: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pla_term_plane.sv
`timescale 1ns/1ps
module pla_term_plane
    import pla_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16,
    parameter int IDX_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [2*N_IN-1:0]    wr_row,
    input  logic [N_IN-1:0]      in_vec,
    output logic [N_TERM-1:0]    term_vec
);

    localparam int ROW_W = 2 * N_IN;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [ROW_W-1:0] row_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(t))) begin
                row_q <= wr_row;
            end
        end

        always_comb begin
            logic acc;
            acc = 1'b1;
            for (int j = 0; j < N_IN; j++) begin
                acc = acc & literal_ok(lit_code_e'(row_q[2*j +: 2]), in_vec[j]);
            end
            term_vec[t] = acc;
        end
    end

endmodule

// File: rtl/pla_sum_plane.sv
`timescale 1ns/1ps
module pla_sum_plane
    import pla_pkg::*;
#(
    parameter int N_TERM    = 16,
    parameter int N_OUT     = 4,
    parameter int IDX_W     = 4,
    parameter bit PAL_MODE  = 1'b0,
    parameter int PAL_GROUP = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [N_TERM-1:0]    wr_mask,
    input  logic [N_TERM-1:0]    term_vec,
    output logic [N_OUT-1:0]     out_vec
);

    function automatic logic [N_TERM-1:0] group_bits(input int k);
        logic [N_TERM-1:0] g;
        g = '0;
        for (int t = 0; t < N_TERM; t++) begin
            if ((t >= k * PAL_GROUP) && (t < (k + 1) * PAL_GROUP)) g[t] = 1'b1;
        end
        return g;
    endfunction

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [N_TERM-1:0] mask_q;
        logic [N_TERM-1:0] reach;

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                mask_q <= wr_mask;
            end
        end

        if (PAL_MODE) begin : g_pal
            localparam logic [N_TERM-1:0] GROUP = group_bits(k);
            assign reach = mask_q & GROUP;
        end else begin : g_full
            assign reach = mask_q;
        end

        assign out_vec[k] = |(term_vec & reach);
    end

endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN      = 4,
    parameter int N_TERM    = 16,
    parameter int N_OUT     = 4,
    parameter bit PAL_MODE  = 1'b0,
    parameter int PAL_GROUP = 4,
    parameter int IDX_W     = pla_pkg::bits_for(pla_pkg::max_of(N_TERM, N_OUT)),
    parameter int DATA_W    = pla_pkg::max_of(2 * N_IN, N_TERM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_plane,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  out_vec
);

    cfg_ctl_t          ctl;
    logic [N_TERM-1:0] term_vec;

    assign ctl.we    = cfg_we;
    assign ctl.plane = plane_sel_e'(cfg_plane);

    pla_term_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .IDX_W  (IDX_W)
    ) u_terms (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctl.we && (ctl.plane == PLANE_TERM)),
        .wr_idx   (cfg_index),
        .wr_row   (cfg_data[2*N_IN-1:0]),
        .in_vec   (in_vec),
        .term_vec (term_vec)
    );

    pla_sum_plane #(
        .N_TERM    (N_TERM),
        .N_OUT     (N_OUT),
        .IDX_W     (IDX_W),
        .PAL_MODE  (PAL_MODE),
        .PAL_GROUP (PAL_GROUP)
    ) u_sums (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctl.we && (ctl.plane == PLANE_SUM)),
        .wr_idx   (cfg_index),
        .wr_mask  (cfg_data[N_TERM-1:0]),
        .term_vec (term_vec),
        .out_vec  (out_vec)
    );

endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk #(
    parameter int N_IN      = 4,
    parameter int N_TERM    = 16,
    parameter int N_OUT     = 4,
    parameter bit PAL_MODE  = 1'b0,
    parameter int PAL_GROUP = 4,
    parameter int IDX_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              cfg_plane,
    input logic [IDX_W-1:0]  cfg_index,
    input logic [N_IN-1:0]   in_vec,
    input logic [N_TERM-1:0] term_vec,
    input logic [N_OUT-1:0]  out_vec
);

    localparam logic [IDX_W:0] OUT_LIMIT = (IDX_W+1)'(N_OUT);

    // R1: the first edge after reset sees a cleared personality
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_vec == '0));

    // R4: an output can only be high when some term is high
    assert_out_needs_term_R4: assert property (@(posedge clk) disable iff (rst)
        (|out_vec) |-> (|term_vec));

    // R6: no strobe, steady inputs -> steady outputs
    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(in_vec) |-> $stable(out_vec)));

    // R7: an output-plane write past the last output leaves everything alone
    assert_stray_index_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_plane && ({1'b0, cfg_index} >= OUT_LIMIT))
            |=> ($stable(in_vec) |-> $stable(out_vec)));

    if (PAL_MODE) begin : g_pal_chk
        for (genvar k = 0; k < N_OUT; k++) begin : g_k
            logic [N_TERM-1:0] grp;
            always_comb begin
                grp = '0;
                for (int t = 0; t < N_TERM; t++) begin
                    if ((t >= k * PAL_GROUP) && (t < (k + 1) * PAL_GROUP)) grp[t] = 1'b1;
                end
            end
            // R8: output k is fed only from its own term group
            assert_group_only_R8: assert property (@(posedge clk) disable iff (rst)
                out_vec[k] |-> (|(term_vec & grp)));
        end
    end

endmodule

bind pla_array pla_array_chk #(
    .N_IN      (N_IN),
    .N_TERM    (N_TERM),
    .N_OUT     (N_OUT),
    .PAL_MODE  (PAL_MODE),
    .PAL_GROUP (PAL_GROUP),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_plane (cfg_plane),
    .cfg_index (cfg_index),
    .in_vec    (in_vec),
    .term_vec  (term_vec),
    .out_vec   (out_vec)
);

// File: tb/test_pla_array.sv
`timescale 1ns/1ps
module test_pla_array;

    localparam logic [1:0] KL = 2'b00;
    localparam logic [1:0] PS = 2'b01;
    localparam logic [1:0] NG = 2'b10;
    localparam logic [1:0] SK = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_plane = 1'b0;
    logic [3:0]  cfg_index = '0;
    logic [15:0] cfg_data = '0;
    logic [3:0]  in_vec = '0;
    logic [3:0]  out_full;
    logic [3:0]  out_pal;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pla_array i_pla_array (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
        .cfg_index(cfg_index), .cfg_data(cfg_data), .in_vec(in_vec), .out_vec(out_full)
    );

    pla_array #(.PAL_MODE(1'b1)) i_pla_array_pal (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
        .cfg_index(cfg_index), .cfg_data(cfg_data), .in_vec(in_vec), .out_vec(out_pal)
    );

    // codes for inputs 3,2,1,0 (A,B,C,D in the 4-input examples)
    function automatic logic [15:0] row4(input logic [1:0] c3, input logic [1:0] c2,
                                         input logic [1:0] c1, input logic [1:0] c0);
        return {8'h00, c3, c2, c1, c0};
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s in=%h actual=%h expected=%h", req, in_vec, act, exp);
        end
    endtask

    task automatic wr(input logic plane, input logic [3:0] idx, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = plane; cfg_index = idx; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [3:0] share_ref(input logic [3:0] v);
        logic a, b, c;
        a = v[2]; b = v[1]; c = v[0];
        return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
    endfunction

    function automatic logic [3:0] gray_ref(input logic [3:0] v);
        logic a, b, c, d, w, x, y, z;
        a = v[3]; b = v[2]; c = v[1]; d = v[0];
        w = a | (b & d) | (b & c);
        x = b & ~c;
        y = b | c;
        z = (~a & ~b & ~c & d) | (b & c & d) | (a & ~d) | (~b & c & ~d);
        return {z, y, x, w};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: cleared personality, every input value
        for (int v = 0; v < 16; v++) begin
            in_vec = 4'(v); #1;
            check("R1 full", out_full, 4'h0);
            check("R1 pal", out_pal, 4'h0);
        end

        // R6: mask first, then a row write held against the edge
        wr(1'b1, 4'd0, 16'h0001);
        in_vec = 4'h0; #1;
        check("R6 mask alone", out_full, 4'h0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = 1'b0; cfg_index = 4'd0; cfg_data = 16'h00FF;
        #1;
        check("R6 before edge", out_full, 4'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R6 after edge", out_full, 4'h1);
        cfg_data = 16'h0000; cfg_index = 4'd0; cfg_plane = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 idle strobe", out_full, 4'h1);

        // R2 / R3: one code per term, one term per output
        do_reset();
        wr(1'b0, 4'd0, row4(SK, SK, SK, PS));
        wr(1'b0, 4'd1, row4(SK, NG, SK, SK));
        wr(1'b0, 4'd2, row4(SK, SK, KL, SK));
        wr(1'b0, 4'd3, row4(SK, SK, SK, SK));
        wr(1'b1, 4'd0, 16'h0001);
        wr(1'b1, 4'd1, 16'h0002);
        wr(1'b1, 4'd2, 16'h0004);
        wr(1'b1, 4'd3, 16'h0008);
        for (int v = 0; v < 16; v++) begin
            in_vec = 4'(v); #1;
            check("R2 R3 R10 codes", out_full, {1'b1, 1'b0, ~in_vec[2], in_vec[0]});
        end

        // R7: stray output index must not disturb anything
        wr(1'b1, 4'd4, 16'hFFFF);
        wr(1'b1, 4'd15, 16'hFFFF);
        for (int v = 0; v < 16; v++) begin
            in_vec = 4'(v); #1;
            check("R7 stray write", out_full, {1'b1, 1'b0, ~in_vec[2], in_vec[0]});
        end

        // R4 / R5: shared terms over A,B,C on inputs 2..0
        do_reset();
        wr(1'b0, 4'd0, row4(SK, PS, PS, SK));   // AB
        wr(1'b0, 4'd1, row4(SK, SK, NG, PS));   // B'C
        wr(1'b0, 4'd2, row4(SK, PS, SK, NG));   // AC'
        wr(1'b0, 4'd3, row4(SK, SK, NG, NG));   // B'C'
        wr(1'b0, 4'd4, row4(SK, PS, SK, SK));   // A
        wr(1'b1, 4'd0, 16'h0018);
        wr(1'b1, 4'd1, 16'h0005);
        wr(1'b1, 4'd2, 16'h0009);
        wr(1'b1, 4'd3, 16'h0012);
        for (int v = 0; v < 16; v++) begin
            in_vec = 4'(v); #1;
            check("R4 R5 shared", out_full, share_ref(in_vec));
        end

        // R9: BCD-to-Gray in group-friendly slots, both variants
        do_reset();
        wr(1'b0, 4'd0,  row4(PS, SK, SK, SK));
        wr(1'b0, 4'd1,  row4(SK, PS, SK, PS));
        wr(1'b0, 4'd2,  row4(SK, PS, PS, SK));
        wr(1'b0, 4'd4,  row4(SK, PS, NG, SK));
        wr(1'b0, 4'd8,  row4(SK, PS, SK, SK));
        wr(1'b0, 4'd9,  row4(SK, SK, PS, SK));
        wr(1'b0, 4'd12, row4(NG, NG, NG, PS));
        wr(1'b0, 4'd13, row4(SK, PS, PS, PS));
        wr(1'b0, 4'd14, row4(PS, SK, SK, NG));
        wr(1'b0, 4'd15, row4(SK, NG, PS, NG));
        wr(1'b1, 4'd0, 16'h0007);
        wr(1'b1, 4'd1, 16'h0010);
        wr(1'b1, 4'd2, 16'h0300);
        wr(1'b1, 4'd3, 16'hF000);
        for (int v = 0; v < 16; v++) begin
            in_vec = 4'(v); #1;
            check("R9 gray full", out_full, gray_ref(in_vec));
            check("R9 gray pal", out_pal, gray_ref(in_vec));
        end

        // R8: mask bits outside the group are dropped only in the restricted variant
        do_reset();
        wr(1'b0, 4'd4, row4(SK, SK, SK, SK));
        wr(1'b1, 4'd0, 16'hFFF0);
        wr(1'b1, 4'd1, 16'h00F0);
        for (int v = 0; v < 16; v += 5) begin
            in_vec = 4'(v); #1;
            check("R8 full", out_full, 4'b0011);
            check("R8 pal", out_pal, 4'b0010);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule